// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block sits beside a processor's exception logic and decides, each cycle, whether the pending interrupt level is accepted. When a level is accepted, the block updates the status word, the saved program counter and the saved status, and the cause register on one clock edge. At that same edge it presents the address execution must continue from, together with a single-cycle taken pulse.

Levels above 1 are handled directly. Each such level has its own slot for the interrupted PC and the interrupted status word, and the redirect goes to that level's own vector. Level 1 is folded into the general exception path. It loads a fixed cause code and is reported as a user, kernel or double exception, depending on the user bit and the exception-hold bit of the incoming status word. A build option relocates every vector against a runtime base address.

The status word uses bits [3:0] as the current interrupt level, bit 4 as the exception-hold bit and bit 5 as the user-mode bit. The class code is 0 for a high level, 1 for user, 2 for kernel and 3 for double. The flat saved-PC bus carries level n at bits [(n-1)*PC_W +: PC_W]. The flat saved-status bus carries level n (n at least 2) at bits [(n-2)*STAT_W +: STAT_W].

Top module: `idu_dispatch`

## Requirements
- R1: A pending level is accepted only when it is nonzero, is no greater than NLVL (default 6), and is strictly greater than the current level. The current level is stat_i[3:0], raised to XLVL (default 0) when stat_i bit 4 is set.
- R2: A level is accepted only when the AND of its mask constant, irq_raw_i and irq_en_i is nonzero. The default masks give level 1 bits [3:0], level 2 bits [5:4], level 3 bits [7:6], level 4 bits [9:8], level 5 bits [11:10] and level 6 bits [15:12].
- R3: On accepting a level n above 1, pc_i is stored in saved-PC slot n and stat_i is stored in saved-status slot n.
- R4: On accepting a level n above 1, stat_o becomes stat_i with bits [3:0] replaced by n and bit 4 set. cls_o becomes 0 and redir_o becomes that level's vector.
- R5: On accepting level 1, cause_o is loaded with L1_CAUSE (default 4) and stat_o becomes stat_i with bit 4 set.
- R6: On accepting level 1 while stat_i bit 4 is set, cls_o is 3 and redir_o is the double vector. pc_i goes to dpc_o when DPC_EN is 1; otherwise it goes to saved-PC slot 1.
- R7: On accepting level 1 while stat_i bit 4 is clear, pc_i goes to saved-PC slot 1. cls_o is 1 with the user vector if stat_i bit 5 is set; otherwise cls_o is 2 with the kernel vector.
- R8: With RELOC set, redir_o is the selected vector minus DEF_BASE plus vbase_i, taken modulo 2^PC_W.
- R9: All updates land on one clock edge, and take_o is high only in the cycle after an accepted request. In all other cycles, stat_o, cls_o, redir_o, cause_o and all saved registers hold their values.
- R10: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pend_lvl_i | input | 4 | Highest pending interrupt level, 0 for none |
| irq_raw_i | input | IRQ_W | Raw interrupt request bits |
| irq_en_i | input | IRQ_W | Per-bit interrupt enables |
| stat_i | input | STAT_W | Current processor status word |
| pc_i | input | PC_W | PC of the instruction being interrupted |
| vbase_i | input | PC_W | Runtime vector base |
| take_o | output | 1 | One-cycle pulse: an interrupt was accepted |
| cls_o | output | 2 | Dispatch class of the last accepted interrupt |
| redir_o | output | PC_W | Redirect address of the last accepted interrupt |
| stat_o | output | STAT_W | Updated status word |
| cause_o | output | CAUSE_W | Exception cause register |
| epc_o | output | NLVL*PC_W | Saved-PC slots, one per level |
| eps_o | output | (NLVL-1)*STAT_W | Saved-status slots for levels 2 to NLVL |
| dpc_o | output | PC_W | Saved PC of a double exception |

## Verification
Some properties are checked on every cycle. Each accepted request must have had a level in range, above the incoming interrupt level, and a nonzero enabled request. A high-level acceptance must show the hold bit set and the accepted level in the status output. A level-1 acceptance must show the cause code. The double and user classes must follow from the incoming status bits. Outside a taken cycle, the status, cause and saved slots must not move. Which slot receives which value, the exact vector and relocation arithmetic, and rejection at the configured-level and equal-level boundaries can only be shown by the bench's scenarios, which it compares against an independent reference model.

// File: rtl/idu_pkg.sv
`timescale 1ns/1ps
package idu_pkg;
   localparam int LVL_W   = 4;
   localparam int ST_HOLD = 4;
   localparam int ST_USER = 5;
   localparam int ST_MIN  = 6;

   typedef enum logic [1:0] {
      CLS_HIGH = 2'd0,
      CLS_USER = 2'd1,
      CLS_KERN = 2'd2,
      CLS_DBL  = 2'd3
   } dsp_cls_e;
endpackage

// File: rtl/idu_qual.sv
`timescale 1ns/1ps
// Acceptance test: level window against the current level, then mask gating.
module idu_qual
   import idu_pkg::*;
#(
   parameter int NLVL   = 6,
   parameter int XLVL   = 0,
   parameter int IRQ_W  = 16,
   parameter int STAT_W = 8,
   parameter logic [NLVL:1][IRQ_W-1:0] LVL_MASK = '0
) (
   input  logic [LVL_W-1:0]  pend_lvl,
   input  logic [STAT_W-1:0] stat,
   input  logic [IRQ_W-1:0]  raw,
   input  logic [IRQ_W-1:0]  en,
   output logic              take
);
   localparam logic [LVL_W-1:0] TOP_L  = LVL_W'(NLVL);
   localparam logic [LVL_W-1:0] HOLD_L = LVL_W'(XLVL);

   logic [LVL_W-1:0] cur_lvl;
   logic [IRQ_W-1:0] sel_mask;

   always_comb begin
      cur_lvl = stat[LVL_W-1:0];
      if (stat[ST_HOLD] && (cur_lvl < HOLD_L))
         cur_lvl = HOLD_L;
   end

   always_comb begin
      sel_mask = '0;
      for (int l = 1; l <= NLVL; l++)
         if (pend_lvl == LVL_W'(l))
            sel_mask = LVL_MASK[l];
   end

   assign take = (pend_lvl > cur_lvl) && (pend_lvl <= TOP_L)
               && (|(sel_mask & raw & en));
endmodule

// File: rtl/idu_reloc.sv
`timescale 1ns/1ps
// Vector relocation against a runtime base, or a pass-through.
module idu_reloc #(
   parameter int              PC_W     = 32,
   parameter bit              RELOC    = 1'b1,
   parameter logic [PC_W-1:0] DEF_BASE = '0
) (
   input  logic [PC_W-1:0] vec,
   input  logic [PC_W-1:0] vbase,
   output logic [PC_W-1:0] tgt
);
   generate
      if (RELOC) begin : g_reloc
         assign tgt = vec - DEF_BASE + vbase;
      end else begin : g_fixed
         logic unused_base;
         assign unused_base = ^vbase;
         assign tgt = vec;
      end
   endgenerate
endmodule

// File: rtl/idu_bank.sv
`timescale 1ns/1ps
// Per-level saved PC and saved status slots.
module idu_bank #(
   parameter int NLVL   = 6,
   parameter int PC_W   = 32,
   parameter int STAT_W = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic [NLVL:1]              epc_we,
   input  logic [NLVL:2]              eps_we,
   input  logic [PC_W-1:0]            pc,
   input  logic [STAT_W-1:0]          stat,
   output logic [NLVL*PC_W-1:0]       epc_flat,
   output logic [(NLVL-1)*STAT_W-1:0] eps_flat
);
   generate
      for (genvar g = 1; g <= NLVL; g++) begin : g_pc
         logic [PC_W-1:0] slot_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)          slot_q <= '0;
            else if (epc_we[g]) slot_q <= pc;
         end
         assign epc_flat[(g-1)*PC_W +: PC_W] = slot_q;
      end
      for (genvar g = 2; g <= NLVL; g++) begin : g_st
         logic [STAT_W-1:0] slot_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)          slot_q <= '0;
            else if (eps_we[g]) slot_q <= stat;
         end
         assign eps_flat[(g-2)*STAT_W +: STAT_W] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/idu_dispatch.sv
`timescale 1ns/1ps
module idu_dispatch
   import idu_pkg::*;
#(
   parameter int              NLVL     = 6,
   parameter int              XLVL     = 0,
   parameter int              PC_W     = 32,
   parameter int              STAT_W   = 8,
   parameter int              IRQ_W    = 16,
   parameter int              CAUSE_W  = 8,
   parameter bit              RELOC    = 1'b1,
   parameter bit              DPC_EN   = 1'b1,
   parameter logic [CAUSE_W-1:0] L1_CAUSE = 8'd4,
   parameter logic [PC_W-1:0] DEF_BASE = 32'h4000_0000,
   parameter logic [PC_W-1:0] KERN_VEC = 32'h4000_0300,
   parameter logic [PC_W-1:0] USER_VEC = 32'h4000_0340,
   parameter logic [PC_W-1:0] DBL_VEC  = 32'h4000_03C0,
   parameter logic [NLVL:1][PC_W-1:0] LVL_VEC = {
      32'h4000_0280, 32'h4000_0240, 32'h4000_0200,
      32'h4000_01C0, 32'h4000_0180, 32'h4000_0000},
   parameter logic [NLVL:1][IRQ_W-1:0] LVL_MASK = {
      16'hF000, 16'h0C00, 16'h0300, 16'h00C0, 16'h0030, 16'h000F}
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic [LVL_W-1:0]           pend_lvl_i,
   input  logic [IRQ_W-1:0]           irq_raw_i,
   input  logic [IRQ_W-1:0]           irq_en_i,
   input  logic [STAT_W-1:0]          stat_i,
   input  logic [PC_W-1:0]            pc_i,
   input  logic [PC_W-1:0]            vbase_i,
   output logic                       take_o,
   output logic [1:0]                 cls_o,
   output logic [PC_W-1:0]            redir_o,
   output logic [STAT_W-1:0]          stat_o,
   output logic [CAUSE_W-1:0]         cause_o,
   output logic [NLVL*PC_W-1:0]       epc_o,
   output logic [(NLVL-1)*STAT_W-1:0] eps_o,
   output logic [PC_W-1:0]            dpc_o
);
   generate
      if (NLVL < 2 || NLVL > (2**LVL_W) - 1) begin : g_bad_nlvl
         $error("idu_dispatch: NLVL out of range");
      end
      if (XLVL < 0 || XLVL > NLVL) begin : g_bad_xlvl
         $error("idu_dispatch: XLVL out of range");
      end
      if (STAT_W < ST_MIN) begin : g_bad_stat
         $error("idu_dispatch: status word too narrow");
      end
   endgenerate

   logic            take;
   logic            is_high;
   logic            hold_in;
   dsp_cls_e        cls_d;
   logic [PC_W-1:0] vec_d;
   logic [PC_W-1:0] tgt_d;
   logic [STAT_W-1:0] stat_d;
   logic [NLVL:1]   epc_we;
   logic [NLVL:2]   eps_we;
   logic            dbl_pc_sel;

   idu_qual #(
      .NLVL(NLVL), .XLVL(XLVL), .IRQ_W(IRQ_W), .STAT_W(STAT_W),
      .LVL_MASK(LVL_MASK)
   ) u_qual (
      .pend_lvl(pend_lvl_i), .stat(stat_i), .raw(irq_raw_i),
      .en(irq_en_i), .take(take)
   );

   assign is_high    = pend_lvl_i > LVL_W'(1);
   assign hold_in    = stat_i[ST_HOLD];
   assign dbl_pc_sel = DPC_EN && !is_high && hold_in;

   always_comb begin
      if (is_high)             cls_d = CLS_HIGH;
      else if (hold_in)        cls_d = CLS_DBL;
      else if (stat_i[ST_USER]) cls_d = CLS_USER;
      else                     cls_d = CLS_KERN;
   end

   always_comb begin
      vec_d = KERN_VEC;
      unique case (cls_d)
         CLS_USER: vec_d = USER_VEC;
         CLS_DBL:  vec_d = DBL_VEC;
         CLS_KERN: vec_d = KERN_VEC;
         CLS_HIGH: begin
            for (int l = 2; l <= NLVL; l++)
               if (pend_lvl_i == LVL_W'(l))
                  vec_d = LVL_VEC[l];
         end
      endcase
   end

   idu_reloc #(
      .PC_W(PC_W), .RELOC(RELOC), .DEF_BASE(DEF_BASE)
   ) u_reloc (
      .vec(vec_d), .vbase(vbase_i), .tgt(tgt_d)
   );

   always_comb begin
      stat_d          = stat_i;
      stat_d[ST_HOLD] = 1'b1;
      if (is_high)
         stat_d[LVL_W-1:0] = pend_lvl_i;
   end

   always_comb begin
      epc_we = '0;
      eps_we = '0;
      if (take) begin
         if (is_high) begin
            for (int l = 2; l <= NLVL; l++)
               if (pend_lvl_i == LVL_W'(l)) begin
                  epc_we[l] = 1'b1;
                  eps_we[l] = 1'b1;
               end
         end else if (!dbl_pc_sel) begin
            epc_we[1] = 1'b1;
         end
      end
   end

   idu_bank #(
      .NLVL(NLVL), .PC_W(PC_W), .STAT_W(STAT_W)
   ) u_bank (
      .clk_i(clk_i), .rst_i(rst_i), .epc_we(epc_we), .eps_we(eps_we),
      .pc(pc_i), .stat(stat_i), .epc_flat(epc_o), .eps_flat(eps_o)
   );

   generate
      if (DPC_EN) begin : g_dpc
         logic [PC_W-1:0] dpc_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)                   dpc_q <= '0;
            else if (take && dbl_pc_sel) dpc_q <= pc_i;
         end
         assign dpc_o = dpc_q;
      end else begin : g_no_dpc
         assign dpc_o = '0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         take_o  <= 1'b0;
         cls_o   <= 2'd0;
         redir_o <= '0;
         stat_o  <= '0;
         cause_o <= '0;
      end else begin
         take_o <= take;
         if (take) begin
            cls_o   <= cls_d;
            redir_o <= tgt_d;
            stat_o  <= stat_d;
            if (!is_high)
               cause_o <= L1_CAUSE;
         end
      end
   end
endmodule

// File: rtl/idu_dispatch_chk.sv
`timescale 1ns/1ps
module idu_dispatch_chk
   import idu_pkg::*;
#(
   parameter int NLVL    = 6,
   parameter int PC_W    = 32,
   parameter int STAT_W  = 8,
   parameter int IRQ_W   = 16,
   parameter int CAUSE_W = 8,
   parameter logic [CAUSE_W-1:0] L1_CAUSE = 8'd4
) (
   input logic                       clk_i,
   input logic                       rst_i,
   input logic [LVL_W-1:0]           pend_lvl_i,
   input logic [IRQ_W-1:0]           irq_raw_i,
   input logic [IRQ_W-1:0]           irq_en_i,
   input logic [STAT_W-1:0]          stat_i,
   input logic                       take_o,
   input logic [1:0]                 cls_o,
   input logic [STAT_W-1:0]          stat_o,
   input logic [CAUSE_W-1:0]         cause_o,
   input logic [NLVL*PC_W-1:0]       epc_o,
   input logic [(NLVL-1)*STAT_W-1:0] eps_o
);
   p_lvl_window_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      take_o |-> ($past(pend_lvl_i) != '0) && ($past(pend_lvl_i) <= LVL_W'(NLVL))
                 && ($past(pend_lvl_i) > $past(stat_i[LVL_W-1:0])));

   p_gate_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      take_o |-> (|($past(irq_raw_i) & $past(irq_en_i))));

   p_high_stat_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (take_o && cls_o == CLS_HIGH) |->
         stat_o[ST_HOLD] && (stat_o[LVL_W-1:0] == $past(pend_lvl_i)));

   p_l1_cause_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (take_o && cls_o != CLS_HIGH) |-> (cause_o == L1_CAUSE) && stat_o[ST_HOLD]);

   p_dbl_class_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (take_o && cls_o == CLS_DBL) |-> $past(stat_i[ST_HOLD]));

   p_user_class_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (take_o && cls_o == CLS_USER) |->
         $past(stat_i[ST_USER]) && !$past(stat_i[ST_HOLD]));

   p_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !take_o |-> $stable(stat_o) && $stable(cause_o) && $stable(epc_o)
                  && $stable(eps_o));
endmodule

bind idu_dispatch idu_dispatch_chk #(
   .NLVL(NLVL), .PC_W(PC_W), .STAT_W(STAT_W), .IRQ_W(IRQ_W),
   .CAUSE_W(CAUSE_W), .L1_CAUSE(L1_CAUSE)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .pend_lvl_i(pend_lvl_i),
   .irq_raw_i(irq_raw_i), .irq_en_i(irq_en_i), .stat_i(stat_i),
   .take_o(take_o), .cls_o(cls_o), .stat_o(stat_o), .cause_o(cause_o),
   .epc_o(epc_o), .eps_o(eps_o)
);

// File: tb/idu_dispatch_tb_top.sv
`timescale 1ns/1ps
module idu_dispatch_tb_top;
   localparam int NLVL = 6;
   localparam logic [31:0] BASE = 32'h4000_0000;

   typedef struct {
      logic         take;
      logic [1:0]   cls;
      logic [31:0]  redir;
      logic [7:0]   stat;
      logic [7:0]   cause;
      logic [191:0] epc;
      logic [39:0]  eps;
      logic [31:0]  dpc;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst;
   logic [3:0]   pend;
   logic [15:0]  raw, en;
   logic [7:0]   st;
   logic [31:0]  pc, vb;
   logic         take_o;
   logic [1:0]   cls_o;
   logic [31:0]  redir_o, dpc_o;
   logic [7:0]   stat_o, cause_o;
   logic [191:0] epc_o;
   logic [39:0]  eps_o;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   logic [31:0] m_epc [1:6];
   logic [7:0]  m_eps [2:6];
   logic [31:0] m_dpc, m_redir;
   logic [7:0]  m_stat, m_cause;
   logic [1:0]  m_cls;

   always #2.5 clk = ~clk;

   idu_dispatch dut_i (
      .clk_i(clk), .rst_i(rst), .pend_lvl_i(pend), .irq_raw_i(raw),
      .irq_en_i(en), .stat_i(st), .pc_i(pc), .vbase_i(vb),
      .take_o(take_o), .cls_o(cls_o), .redir_o(redir_o), .stat_o(stat_o),
      .cause_o(cause_o), .epc_o(epc_o), .eps_o(eps_o), .dpc_o(dpc_o)
   );

   function automatic logic [15:0] lvl_mask(input int l);
      case (l)
         1: return 16'h000F;
         2: return 16'h0030;
         3: return 16'h00C0;
         4: return 16'h0300;
         5: return 16'h0C00;
         6: return 16'hF000;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [31:0] lvl_vec(input int l);
      return BASE + 32'h100 + 32'(l) * 32'h40;
   endfunction

   task automatic drive(input logic [3:0] l, input logic [15:0] r,
                        input logic [15:0] e, input logic [7:0] s,
                        input logic [31:0] p, input logic [31:0] b,
                        input string tag);
      exp_t x;
      int   cur;
      logic tk;
      logic [31:0] v;
      @(negedge clk);
      pend = l; raw = r; en = e; st = s; pc = p; vb = b;
      cur = int'(s[3:0]);
      tk  = (int'(l) > cur) && (l != 0) && (int'(l) <= NLVL)
            && ((lvl_mask(int'(l)) & r & e) != 16'h0);
      if (tk) begin
         if (l > 1) begin
            m_epc[int'(l)] = p;
            m_eps[int'(l)] = s;
            m_stat = (s & 8'hF0) | {4'h0, l} | 8'h10;
            m_cls  = 2'd0;
            v      = lvl_vec(int'(l));
         end else begin
            m_cause = 8'd4;
            m_stat  = s | 8'h10;
            if (s[4]) begin
               m_cls = 2'd3; m_dpc = p; v = BASE + 32'h3C0;
            end else begin
               m_epc[1] = p;
               m_cls = s[5] ? 2'd1 : 2'd2;
               v     = s[5] ? BASE + 32'h340 : BASE + 32'h300;
            end
         end
         m_redir = v - BASE + b;
      end
      x.take = tk; x.cls = m_cls; x.redir = m_redir; x.stat = m_stat;
      x.cause = m_cause; x.dpc = m_dpc; x.tag = tag;
      for (int i = 1; i <= 6; i++) x.epc[(i-1)*32 +: 32] = m_epc[i];
      for (int i = 2; i <= 6; i++) x.eps[(i-2)*8 +: 8] = m_eps[i];
      q.push_back(x);
   endtask

   task automatic idle(input string tag);
      drive(4'd0, 16'h0, 16'h0, 8'h00, 32'h0, BASE, tag);
   endtask

   initial begin : monitor
      exp_t x;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            x = q.pop_front();
            n_chk++;
            if (take_o !== x.take || cls_o !== x.cls || redir_o !== x.redir
                || stat_o !== x.stat || cause_o !== x.cause
                || epc_o !== x.epc || eps_o !== x.eps || dpc_o !== x.dpc) begin
               n_bad++;
               $display("FAIL %s: actual take=%0b cls=%0d redir=%h stat=%h cause=%h dpc=%h epc=%h eps=%h expected take=%0b cls=%0d redir=%h stat=%h cause=%h dpc=%h epc=%h eps=%h",
                  x.tag, take_o, cls_o, redir_o, stat_o, cause_o, dpc_o, epc_o, eps_o,
                  x.take, x.cls, x.redir, x.stat, x.cause, x.dpc, x.epc, x.eps);
            end
         end
      end
   end

   initial begin : watchdog
      #(100000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      rst = 1'b1; pend = '0; raw = '0; en = '0; st = '0; pc = '0; vb = BASE;
      for (int i = 1; i <= 6; i++) m_epc[i] = '0;
      for (int i = 2; i <= 6; i++) m_eps[i] = '0;
      m_dpc = '0; m_redir = '0; m_stat = '0; m_cause = '0; m_cls = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R10: reset values visible at the ports
      n_chk++;
      if (take_o !== 1'b0 || cls_o !== 2'd0 || redir_o !== '0 || stat_o !== '0
          || cause_o !== '0 || epc_o !== '0 || eps_o !== '0 || dpc_o !== '0) begin
         n_bad++;
         $display("FAIL R10 reset: actual take=%0b stat=%h cause=%h redir=%h expected all zero",
                  take_o, stat_o, cause_o, redir_o);
      end
      drive(4'd3, 16'h0040, 16'hFFFF, 8'h00, 32'h1000_0010, BASE, "R3 R4 level 3 from idle");
      idle("R9 pulse drops, state held");
      drive(4'd2, 16'h0010, 16'hFFFF, 8'h02, 32'h1000_0020, BASE, "R1 equal level rejected");
      drive(4'd7, 16'hFFFF, 16'hFFFF, 8'h00, 32'h1000_0030, BASE, "R1 beyond configured levels");
      drive(4'd4, 16'h0300, 16'h00FF, 8'h00, 32'h1000_0040, BASE, "R2 disabled request");
      drive(4'd4, 16'h0040, 16'hFFFF, 8'h00, 32'h1000_0050, BASE, "R2 request of another level");
      drive(4'd6, 16'h8000, 16'hFFFF, 8'h05, 32'h1000_0060, BASE, "R1 R3 R4 top level");
      drive(4'd1, 16'h0001, 16'hFFFF, 8'h20, 32'h1000_0070, BASE, "R5 R7 user class");
      drive(4'd1, 16'h0002, 16'hFFFF, 8'h00, 32'h1000_0080, BASE, "R5 R7 kernel class");
      drive(4'd1, 16'h0004, 16'hFFFF, 8'h10, 32'h1000_0090, BASE, "R5 R6 double class");
      drive(4'd2, 16'h0010, 16'hFFFF, 8'h11, 32'h1000_00A0, 32'h8000_0000, "R8 R3 relocated level 2");
      drive(4'd1, 16'h0001, 16'hFFFF, 8'h01, 32'h1000_00B0, BASE, "R1 level 1 below current");
      drive(4'd5, 16'h0400, 16'h0400, 8'h20, 32'h1000_00C0, 32'h2000_0000, "R4 R8 level 5 relocated");
      drive(4'd2, 16'h0020, 16'hFFFF, 8'h00, 32'h1000_00D0, BASE, "R9 back-to-back take");
      idle("R9 idle after sequence");
      idle("R9 held values");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule